// File: doc/BRIEF.md
# MDIO Management Command Controller

This block is a register-driven management master for clause-22 PHY access. A host loads a 16-bit data register and then writes a 16-bit control word. That single control-word write launches one complete serial management frame on MDC/MDIO. When the frame ends, the result of a read lands in the same data register. Software polls a finish flag to see that the engine is idle again before it issues the next command.

The serial clock is made from the system clock by a parameterised divider. One MDC bit period lasts `2*DIV_HALF` system cycles, with the low half first, and MDC rests low between transactions. The MDIO pad is split into an output value, an output enable and an input, so the tristate buffer can sit in the pad ring.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset, `done` is 1, `mdc` is 0, `mdio_oe` is 0 and `data_rdata` is 0.
- R2: While `done` is 1, a `data_wr` pulse loads `data_wdata` into the data register, and the new value is visible on `data_rdata` in the following cycle.
- R3: The control word is decoded as follows: bit 13 = 1 selects a write and 0 selects a read, bits 12:8 are the PHY address, and bits 4:0 are the register number. Bits 15:14 and 7:5 have no effect on the frame.
- R4: A transaction shifts out 64 bits, MSB first, one per MDC period. The order is 32 ones, start `01`, opcode (`01` write, `10` read), five PHY address bits, five register bits, two turnaround bits, then 16 data bits.
- R5: While a transaction runs, MDC is low for the first `DIV_HALF` cycles of each bit and high for the next `DIV_HALF` cycles. MDC is 0 whenever `done` is 1.
- R6: In a write, `mdio_oe` is 1 for all 64 bits, the turnaround is driven as `10`, and the data bits carry the data register contents.
- R7: In a read, `mdio_oe` is 1 only for bits 0 to 45 and is 0 from the turnaround onward. `mdio_i` is sampled in the cycle in which MDC rises during bits 48 to 63. The 16 sampled bits, first one as MSB, appear on `data_rdata` in the cycle after the last bit ends.
- R8: A control write accepted while `done` is 1 clears `done` in the next cycle. `done` returns to 1 exactly `128*DIV_HALF` cycles after the accepting edge, one cycle after the last data bit's high half.
- R9: While `done` is 0, `ctl_wr` and `data_wr` are ignored. No frame is restarted and the data register keeps its value.
- R10: If `data_wr` and `ctl_wr` arrive in the same idle cycle, a write frame carries the new `data_wdata`, and the data register takes that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_wr | input | 1 | Write strobe for the data register |
| data_wdata | input | 16 | Value for the data register |
| ctl_wr | input | 1 | Write strobe for the control word; launches a transaction |
| ctl_wdata | input | 16 | Control word (bit 13 write select, 12:8 PHY, 4:0 register) |
| data_rdata | output | 16 | Data register contents (write data or read result) |
| done | output | 1 | Finish flag, 1 when idle |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO value from the pad |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The expected timing is fixed and follows directly from the accepting edge. `done` falls one cycle after an accepted control write. Each bit's MDC low and high halves each last `DIV_HALF` cycles from that edge. Read data and the rise of `done` are due exactly `128*DIV_HALF` edges later. The bench counts these edges in a behavioural model and compares every output at the falling clock edge of every cycle. A PHY model in the bench drives read data after each MDC fall, so the rising-edge sampling of R7 is exercised with a real margin.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_BIT     = 46;
  localparam int DATA_BIT   = 48;

  typedef struct packed {
    logic       wr;
    logic [4:0] phy;
    logic [4:0] regn;
  } mdio_cmd_t;

  function automatic mdio_cmd_t decode_ctl(input logic [15:0] w);
    mdio_cmd_t c;
    c.wr   = w[13];
    c.phy  = w[12:8];
    c.regn = w[4:0];
    return c;
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t c,
                                                        input logic [15:0] d);
    logic [1:0]  op;
    logic [1:0]  ta;
    logic [15:0] pay;
    op  = c.wr ? 2'b01 : 2'b10;
    ta  = c.wr ? 2'b10 : 2'b00;
    pay = c.wr ? d : 16'h0000;
    return {32'hFFFF_FFFF, 2'b01, op, c.phy, c.regn, ta, pay};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (DIV_HALF < 2) ? 1 : $clog2(DIV_HALF);
  localparam logic [CW-1:0] CNT_END = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          at_end;

  assign at_end = run_i && (cnt_q == CNT_END);
  assign rise_o = at_end && !mdc_q;
  assign fall_o = at_end && mdc_q;
  assign mdc_o  = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (start_i) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (run_i) begin
      if (at_end) begin
        cnt_d = '0;
        mdc_d = ~mdc_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  AST_MDC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && !at_end && !start_i |=> $stable(mdc_q)); // R5
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  input  logic                  rd_i,
  input  logic                  rise_i,
  input  logic                  fall_i,
  input  logic                  mdio_i,
  output logic                  busy_o,
  output logic                  rd_o,
  output logic                  last_o,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic [15:0]           rd_data_o
);
  localparam logic [5:0] IDX_LAST = 6'(FRAME_BITS - 1);
  localparam logic [5:0] IDX_TA   = 6'(TA_BIT);
  localparam logic [5:0] IDX_DATA = 6'(DATA_BIT);

  logic                  busy_q, busy_d;
  logic                  rd_q, rd_d;
  logic [5:0]            idx_q, idx_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [15:0]           cap_q, cap_d;

  assign busy_o    = busy_q;
  assign rd_o      = rd_q;
  assign last_o    = busy_q && fall_i && (idx_q == IDX_LAST);
  assign mdio_o    = sh_q[FRAME_BITS-1];
  assign mdio_oe   = busy_q && (!rd_q || (idx_q < IDX_TA));
  assign rd_data_o = cap_q;

  always_comb begin
    busy_d = busy_q;
    rd_d   = rd_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    cap_d  = cap_q;
    if (start_i) begin
      busy_d = 1'b1;
      rd_d   = rd_i;
      idx_d  = '0;
      sh_d   = frame_i;
      cap_d  = '0;
    end else if (busy_q) begin
      if (rise_i && rd_q && (idx_q >= IDX_DATA))
        cap_d = {cap_q[14:0], mdio_i};
      if (fall_i) begin
        if (idx_q == IDX_LAST) begin
          busy_d = 1'b0;
        end else begin
          idx_d = idx_q + 6'd1;
          sh_d  = {sh_q[FRAME_BITS-2:0], 1'b1};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
      cap_q  <= '0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      cap_q  <= cap_d;
    end
  end

  AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_q && (idx_q == 6'd0)); // R4
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        data_wr,
  input  logic [15:0] data_wdata,
  input  logic        ctl_wr,
  input  logic [15:0] ctl_wdata,
  output logic [15:0] data_rdata,
  output logic        done,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic                  done_q, done_d;
  logic [15:0]           data_q, data_d;
  logic                  start;
  logic                  busy, eng_rd, last, rise, fall;
  logic [15:0]           cap;
  mdio_cmd_t             cmd;
  logic [15:0]           frame_data;
  logic [FRAME_BITS-1:0] frame;

  assign start      = ctl_wr && done_q;
  assign cmd        = decode_ctl(ctl_wdata);
  assign frame_data = data_wr ? data_wdata : data_q;
  assign frame      = build_frame(cmd, frame_data);

  mdio_mdc_gen #(.DIV_HALF(DIV_HALF)) u_mdc (
    .clk(clk), .rst_n(rst_n), .start_i(start), .run_i(busy),
    .mdc_o(mdc), .rise_o(rise), .fall_o(fall)
  );

  mdio_frame_eng u_eng (
    .clk(clk), .rst_n(rst_n), .start_i(start), .frame_i(frame),
    .rd_i(!cmd.wr), .rise_i(rise), .fall_i(fall), .mdio_i(mdio_i),
    .busy_o(busy), .rd_o(eng_rd), .last_o(last),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data_o(cap)
  );

  always_comb begin
    data_d = data_q;
    done_d = done_q;
    if (done_q && data_wr)
      data_d = data_wdata;
    else if (last && eng_rd)
      data_d = cap;
    if (start)
      done_d = 1'b0;
    else if (last)
      done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b1;
      data_q <= '0;
    end else begin
      done_q <= done_d;
      data_q <= data_d;
    end
  end

  assign done       = done_q;
  assign data_rdata = data_q;

  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    done && ctl_wr |=> !done); // R8
  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mdc); // R5
  AST_OE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> !done); // R6
  AST_BUSY_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done && data_wr |=> done || $stable(data_rdata)); // R9
endmodule

// File: tb/mdio_cmd_ctrl_bench.sv
module mdio_cmd_ctrl_bench;
  localparam int DH = 2;
  localparam int TXN = 128 * DH;

  logic        clk, rst_n;
  logic        data_wr, ctl_wr;
  logic [15:0] data_wdata, ctl_wdata;
  logic [15:0] data_rdata;
  logic        done, mdc, mdio_i, mdio_o, mdio_oe;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  mdio_cmd_ctrl #(.DIV_HALF(DH)) u_mdio_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_wdata(data_wdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .data_rdata(data_rdata),
    .done(done), .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural reference model
  bit          m_busy, m_read, m_done;
  int          m_t;
  bit [63:0]   m_frame;
  bit [15:0]   m_data, m_cap;
  bit [15:0]   phy_val;
  int          falls;
  bit          prev_mdc;

  function automatic bit [63:0] ref_frame(bit [15:0] c, bit [15:0] d);
    bit [63:0] f;
    f = '1;                       // preamble ones, bits 0..31
    f[31:30] = 2'b01;             // start
    f[29:28] = c[13] ? 2'b01 : 2'b10;
    f[27:23] = c[12:8];
    f[22:18] = c[4:0];
    f[17:16] = c[13] ? 2'b10 : 2'b00;
    f[15:0]  = c[13] ? d : 16'h0;
    return f;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 1; m_data = 0; m_t = 0; m_read = 0; m_cap = 0;
    end else if (m_busy) begin
      if ((m_t % (2*DH)) == DH-1 && (m_t / (2*DH)) >= 48 && m_read)
        m_cap = {m_cap[14:0], mdio_i};
      m_t++;
      if (m_t == TXN) begin
        m_busy = 0; m_done = 1;
        if (m_read) m_data = m_cap;
      end
    end else begin
      if (ctl_wr) begin
        m_frame = ref_frame(ctl_wdata, data_wr ? data_wdata : m_data);
        m_read = !ctl_wdata[13];
        m_busy = 1; m_t = 0; m_done = 0; m_cap = 0;
      end
      if (data_wr) m_data = data_wdata;
    end
  end

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // per-cycle comparison plus PHY model, away from the active edge
  always @(negedge clk) begin
    int bitn;
    bit e_mdc, e_oe;
    cycles++;
    if (rst_n) begin
      bitn  = m_t / (2*DH);
      e_mdc = m_busy && ((m_t / DH) % 2 == 1);
      e_oe  = m_busy && (!m_read || bitn < 46);
      chk(done === m_done, "R8 done", {15'b0, done}, {15'b0, m_done});
      chk(mdc === e_mdc, "R5 mdc", {15'b0, mdc}, {15'b0, e_mdc});
      chk(mdio_oe === e_oe, "R6/R7 oe", {15'b0, mdio_oe}, {15'b0, e_oe});
      chk(data_rdata === m_data, "R2/R7/R9 data", data_rdata, m_data);
      if (e_oe)
        chk(mdio_o === m_frame[63-bitn], "R4 mdio_o bit", {15'b0, mdio_o},
            {15'b0, m_frame[63-bitn]});
    end
    if (!m_busy) falls = 0;
    else if (prev_mdc && !mdc) falls++;
    prev_mdc = mdc;
    mdio_i = (falls >= 48 && falls <= 63) ? phy_val[63-falls] : 1'b1;
  end

  always @(negedge clk) begin
    if (cycles > 150000) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(bit dw, bit [15:0] dv, bit cw, bit [15:0] cv);
    data_wr = dw; data_wdata = dv; ctl_wr = cw; ctl_wdata = cv;
    @(negedge clk);
    data_wr = 0; ctl_wr = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < TXN + 10 && !done; i++) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; data_wr = 0; ctl_wr = 0; data_wdata = 0; ctl_wdata = 0;
    mdio_i = 1; phy_val = 16'h3C69; falls = 0; prev_mdc = 0;
    idle(3);
    // R1 reset state
    chk(done === 1'b1 && mdc === 1'b0 && mdio_oe === 1'b0 && data_rdata === 16'h0,
        "R1 reset", data_rdata, 16'h0);
    rst_n = 1;
    idle(2);
    // R2 data load
    drive(1, 16'hA5C3, 0, 16'h0);
    chk(data_rdata === 16'hA5C3, "R2 load", data_rdata, 16'hA5C3);
    // R3 write with junk bits 15:14 and 7:5 set; PHY 0x11, reg 0x0A
    drive(0, 16'h0, 1, 16'hF1EA);
    chk(done === 1'b0, "R8 clear", {15'b0, done}, 16'h0);
    idle(20);
    // R9 commands while busy are ignored
    drive(1, 16'h1111, 1, 16'h0000);
    idle(5);
    chk(data_rdata === 16'hA5C3, "R9 data hold", data_rdata, 16'hA5C3);
    wait_done();
    chk(done === 1'b1, "R8 set", {15'b0, done}, 16'h1);
    chk(data_rdata === 16'hA5C3, "R6 data kept", data_rdata, 16'hA5C3);
    idle(3);
    // R7 read, PHY 0x03, reg 0x1F, junk bit 14
    drive(0, 16'h0, 1, 16'h431F);
    wait_done();
    chk(data_rdata === 16'h3C69, "R7 read data", data_rdata, 16'h3C69);
    idle(2);
    // R10 simultaneous data and control write
    drive(1, 16'h0F0F, 1, 16'h3F00);
    chk(data_rdata === 16'h0F0F, "R10 data", data_rdata, 16'h0F0F);
    wait_done();
    idle(2);
    // second read with edge pattern
    phy_val = 16'h8001;
    drive(0, 16'h0, 1, 16'h0000);
    wait_done();
    chk(data_rdata === 16'h8001, "R7 read edge bits", data_rdata, 16'h8001);
    idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule